// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block sits behind a keyboard serial receiver and turns its stream of received bytes into key events. Each byte arrives with a one-cycle valid strobe. Two byte values act as prefixes. 0xE0 marks an extended key. 0xF0 marks a key release. Any other byte is a scan code. The scan code closes the sequence and produces exactly one event. The event carries the code unchanged, an extended flag and a release flag.

The decoder remembers only whether each prefix has been seen since the last event. It does not map codes to characters, apply shift state or send commands to the keyboard. Auto-repeat from a held key appears as a series of separate press events. Malformed prefix orders restart tracking from the offending byte, so they never produce a corrupt event.

Top module: `kbd_scan_decoder`

## Requirements
- R1: A valid byte that is neither 0xE0 nor 0xF0, with no prefix pending, produces a press event. In that event `key_release`=0, `key_ext`=0, and `key_code` equals the byte unchanged.
- R2: The sequence 0xF0 then a code produces one event with `key_release`=1 and `key_ext`=0.
- R3: The sequence 0xE0 then a code produces one event with `key_release`=0 and `key_ext`=1.
- R4: The sequence 0xE0, 0xF0, code produces one event with `key_release`=1 and `key_ext`=1.
- R5: Repeated arrivals of the same code each produce a separate press event.
- R6: A valid 0xE0 or 0xF0 byte never raises `key_strobe` on its own.
- R7: After every event, both prefix flags are cleared, so the next plain code is reported as a plain press.
- R8: A 0xE0 received while a release prefix is pending restarts tracking as extended only. A second 0xF0 restarts tracking as release only and drops any earlier 0xE0.
- R9: `key_strobe` is high for exactly one cycle, in the cycle after the code byte's `byte_valid`. `key_code`, `key_ext` and `key_release` hold their values between events.
- R10: Synchronous reset drives all outputs to 0 and clears any pending prefix.
- R11: A byte presented while `byte_valid` is low has no effect on the outputs or on the prefix state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_in | input | 8 | Received byte from the keyboard receiver |
| byte_valid | input | 1 | One-cycle strobe qualifying `byte_in` |
| key_code | output | 8 | Scan code of the last event |
| key_ext | output | 1 | Last event came from an extended key |
| key_release | output | 1 | Last event was a release (1) or press (0) |
| key_strobe | output | 1 | One-cycle pulse marking a new event |

## Verification
The assertions check several properties on every cycle. A strobe only ever follows a valid non-prefix byte by one cycle, and it carries that byte as its code. A prefix byte is never followed by a strobe. The prefix flags are empty after each emitted event. Only the bench scenarios can show that whole sequences combine correctly. That covers extended release, the restart rules for F0-E0 and F0-F0, prefixes dropped across a reset, and invalid bytes being ignored. The bench checks each resulting event against an expected queue.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;

    parameter int unsigned CODE_W = 8;

    localparam logic [CODE_W-1:0] PFX_EXTENDED = 8'hE0;
    localparam logic [CODE_W-1:0] PFX_RELEASE  = 8'hF0;

    typedef enum logic [1:0] {
        BYTE_PLAIN = 2'd0,
        BYTE_EXT   = 2'd1,
        BYTE_REL   = 2'd2
    } byte_kind_e;

    typedef struct packed {
        logic ext;
        logic rel;
    } pfx_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ext;
        logic              rel;
    } key_evt_t;

    function automatic byte_kind_e classify(input logic [CODE_W-1:0] b);
        if (b == PFX_EXTENDED)     return BYTE_EXT;
        else if (b == PFX_RELEASE) return BYTE_REL;
        else                       return BYTE_PLAIN;
    endfunction

    // E0 always restarts as extended-only; a repeated F0 restarts as release-only.
    function automatic pfx_state_t next_prefix(input pfx_state_t cur, input byte_kind_e k);
        pfx_state_t n;
        case (k)
            BYTE_EXT: n = '{ext: 1'b1, rel: 1'b0};
            BYTE_REL: n = cur.rel ? '{ext: 1'b0, rel: 1'b1} : '{ext: cur.ext, rel: 1'b1};
            default:  n = '{ext: 1'b0, rel: 1'b0};
        endcase
        return n;
    endfunction

endpackage

// File: rtl/kbd_prefix_tracker.sv
module kbd_prefix_tracker
    import kbd_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_byte,
    output logic              emit,
    output key_evt_t          evt
);

    pfx_state_t pfx_q;
    byte_kind_e kind;

    always_comb begin
        kind     = classify(in_byte);
        emit     = in_valid && (kind == BYTE_PLAIN);
        evt.code = in_byte;
        evt.ext  = pfx_q.ext;
        evt.rel  = pfx_q.rel;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pfx_q <= '0;
        else if (in_valid)
            pfx_q <= next_prefix(pfx_q, kind);
    end

    // R7: prefix state is empty right after an event
    a_r7_clear_after_event: assert property (@(posedge clk) disable iff (rst)
        emit |=> (!pfx_q.ext && !pfx_q.rel));

    // R8: a release byte always leaves the release flag set
    a_r8_release_pending: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte == PFX_RELEASE) |=> pfx_q.rel);

    // R8: an extended byte leaves extended set and release clear
    a_r8_ext_restart: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte == PFX_EXTENDED) |=> (pfx_q.ext && !pfx_q.rel));

    // R11: no valid byte, no change of prefix state
    a_r11_hold_prefix: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(pfx_q));

endmodule

// File: rtl/kbd_event_reg.sv
module kbd_event_reg
    import kbd_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     emit,
    input  key_evt_t evt_in,
    output key_evt_t evt_q,
    output logic     strobe_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= emit;
            if (emit)
                evt_q <= evt_in;
        end
    end

endmodule

// File: rtl/kbd_scan_decoder.sv
module kbd_scan_decoder
    import kbd_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] byte_in,
    input  logic              byte_valid,
    output logic [CODE_W-1:0] key_code,
    output logic              key_ext,
    output logic              key_release,
    output logic              key_strobe
);

    logic     emit;
    key_evt_t evt_next;
    key_evt_t evt_q;

    kbd_prefix_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (byte_valid),
        .in_byte  (byte_in),
        .emit     (emit),
        .evt      (evt_next)
    );

    kbd_event_reg u_oreg (
        .clk      (clk),
        .rst      (rst),
        .emit     (emit),
        .evt_in   (evt_next),
        .evt_q    (evt_q),
        .strobe_q (key_strobe)
    );

    assign key_code    = evt_q.code;
    assign key_ext     = evt_q.ext;
    assign key_release = evt_q.rel;

    // R9: strobe only in the cycle after a valid byte
    a_r9_strobe_timing: assert property (@(posedge clk) disable iff (rst)
        key_strobe |-> $past(byte_valid));

    // R1: the event code is the byte received one cycle earlier
    a_r1_code_passthrough: assert property (@(posedge clk) disable iff (rst)
        key_strobe |-> (key_code == $past(byte_in)));

    // R6: prefix bytes do not produce events
    a_r6_prefix_silent: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && (byte_in == PFX_EXTENDED || byte_in == PFX_RELEASE)) |=> !key_strobe);

    // R5: every valid code byte produces an event
    a_r5_code_emits: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_in != PFX_EXTENDED && byte_in != PFX_RELEASE) |=> key_strobe);

    // R9: event fields hold while no strobe
    a_r9_hold_fields: assert property (@(posedge clk) disable iff (rst)
        !$past(byte_valid) |-> $stable({key_code, key_ext, key_release}));

endmodule

// File: tb/kbd_scan_decoder_tb.sv
module kbd_scan_decoder_tb_top;

    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [7:0] code;
        logic       ext;
        logic       rel;
        string      tag;
    } exp_evt_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] byte_in = 8'h00;
    logic       byte_valid = 1'b0;
    logic [7:0] key_code;
    logic       key_ext;
    logic       key_release;
    logic       key_strobe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    exp_evt_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_scan_decoder dut_i (
        .clk         (clk),
        .rst         (rst),
        .byte_in     (byte_in),
        .byte_valid  (byte_valid),
        .key_code    (key_code),
        .key_ext     (key_ext),
        .key_release (key_release),
        .key_strobe  (key_strobe)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Drive one byte; when it completes a sequence, push the expected event.
    task automatic send(input logic [7:0] b, input bit completes,
                        input bit e_ext, input bit e_rel, input string tag);
        exp_evt_t x;
        @(negedge clk);
        byte_in    = b;
        byte_valid = 1'b1;
        if (completes) begin
            x.code = b; x.ext = e_ext; x.rel = e_rel; x.tag = tag;
            sb_q.push_back(x);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        byte_in    = 8'h00;
        #1;
        check(key_strobe == completes, tag,
              $sformatf("strobe after byte %h: actual %0b expected %0b", b, key_strobe, completes));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare at each strobe.
    always @(negedge clk) begin
        if (!rst && key_strobe) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", $sformatf("unexpected event code %h: actual 1 expected 0 strobes",
                      key_code));
            end else begin
                exp_evt_t x;
                x = sb_q.pop_front();
                check(key_code == x.code && key_ext == x.ext && key_release == x.rel, x.tag,
                      $sformatf("event actual code=%h ext=%0b rel=%0b expected code=%h ext=%0b rel=%0b",
                                key_code, key_ext, key_release, x.code, x.ext, x.rel));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(key_code == 8'h00 && !key_ext && !key_release && !key_strobe, "R10",
              $sformatf("reset outputs actual %h/%0b/%0b/%0b expected 00/0/0/0",
                        key_code, key_ext, key_release, key_strobe));
        rst = 1'b0;
        idle(2);

        send(8'h1C, 1, 0, 0, "R1");                 // plain press
        send(8'hF0, 0, 0, 0, "R6");
        send(8'h1C, 1, 0, 1, "R2");                 // release
        send(8'hE0, 0, 0, 0, "R6");
        send(8'h75, 1, 1, 0, "R3");                 // extended press
        send(8'hE0, 0, 0, 0, "R6");
        send(8'hF0, 0, 0, 0, "R6");
        send(8'h75, 1, 1, 1, "R4");                 // extended release
        send(8'h29, 1, 0, 0, "R7");                 // state cleared after event
        for (int i = 0; i < 4; i++) send(8'h23, 1, 0, 0, "R5");  // auto-repeat

        // R9: outputs hold between events
        idle(3);
        check(key_code == 8'h23 && !key_ext && !key_release && !key_strobe, "R9",
              $sformatf("hold actual %h/%0b/%0b/%0b expected 23/0/0/0",
                        key_code, key_ext, key_release, key_strobe));

        // R8: F0 then E0 restarts as extended press
        send(8'hF0, 0, 0, 0, "R8");
        send(8'hE0, 0, 0, 0, "R8");
        send(8'h6B, 1, 1, 0, "R8");
        // R8: E0 F0 F0 restarts as plain release
        send(8'hE0, 0, 0, 0, "R8");
        send(8'hF0, 0, 0, 0, "R8");
        send(8'hF0, 0, 0, 0, "R8");
        send(8'h6B, 1, 0, 1, "R8");
        // back-to-back bytes, no gap between them
        send(8'hE0, 0, 0, 0, "R6");
        send(8'h11, 1, 1, 0, "R3");

        // R11: bytes without valid are ignored
        @(negedge clk);
        byte_in = 8'hF0;
        @(negedge clk);
        byte_in = 8'h5A;
        @(negedge clk);
        byte_in = 8'h00;
        #1;
        check(!key_strobe && key_code == 8'h11 && key_ext && !key_release, "R11",
              $sformatf("after invalid bytes actual %0b/%h/%0b/%0b expected 0/11/1/0",
                        key_strobe, key_code, key_ext, key_release));
        send(8'h5A, 1, 0, 0, "R11");                // F0 without valid left no prefix

        // R10: reset mid-sequence drops the prefix
        send(8'hE0, 0, 0, 0, "R10");
        send(8'hF0, 0, 0, 0, "R10");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(key_code == 8'h00 && !key_ext && !key_release && !key_strobe, "R10",
              $sformatf("mid reset actual %h/%0b/%0b/%0b expected 00/0/0/0",
                        key_code, key_ext, key_release, key_strobe));
        rst = 1'b0;
        idle(1);
        send(8'h4D, 1, 0, 0, "R10");

        idle(3);
        check(sb_q.size() == 0, "R9",
              $sformatf("pending events actual %0d expected 0", sb_q.size()));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9: watchdog expired, actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule